// File: doc/BRIEF.md
# Eight-Bit Timer/Counter with Steerable Prescaler

This block is a small timer/counter peripheral. An 8-bit count register advances either on the internal instruction-cycle tick, which is the system clock divided by four, or on edges of an external input pin. The active pin edge is selectable. Before it reaches the counter, the pin passes through a two-stage synchronizer and an edge detector.

One 8-bit prescaler serves one user at a time. It either divides the timer's event stream or divides a watchdog base-tick input, and the divided result appears on a watchdog tick output. An 8-to-1 tap multiplexer, driven by a 3-bit rate field, picks the division ratio. Software cannot see the prescaler count.

Software writes the count register, a 6-bit option field and an interrupt-enable bit through strobed write ports, and reads them back on the read ports. A write to the count register holds off counting for the next two instruction cycles. When the count wraps from FFh to 00h, a sticky overflow flag is set. Software clears the flag. The flag is masked by the enable bit to form the interrupt request. A halt input freezes the timer path.

Top module: `tt8_timer`

## Requirements
- R1: Pulsing `cnt_we` loads `wdata` into the count. `cnt_rd` shows the new value after the next clock edge.
- R2: With option bit 5 = 0, the timer path receives one event every 4 clocks, one per instruction cycle. With the prescaler on the watchdog path, each event advances the count by exactly one.
- R3: With option bit 5 = 1, events come from the external pin. Option bit 4 = 0 counts rising edges and bit 4 = 1 counts falling edges.
- R4: A pin change that settles before clock edge k changes `cnt_rd` at edge k+2, the third edge. This accounts for a two-flop synchronizer followed by the count register.
- R5: After a count write, counting events are dropped during the next two instruction cycles. Counting resumes on the third instruction cycle.
- R6: The count wrapping from FFh to 00h sets `ovf_flag`. The flag stays set until `flag_clr` is pulsed. If a set and a clear arrive in the same cycle, the set wins.
- R7: `irq` is high exactly when `ovf_flag` and the enable bit are both high. The enable bit is loaded from `wdata[0]` by `ien_we`, and it does not stop the flag from being set.
- R8: With option bit 3 = 0, the prescaler divides the timer events by 2^(rate+1), where rate is option bits 2:0. `wdt_tick` then repeats `wdt_base` undivided, one clock later.
- R9: With option bit 3 = 1, the count advances on every timer event, and `wdt_tick` pulses once per 2^rate `wdt_base` pulses, one clock after the pulse that completes the ratio. Changing bit 3 clears the prescaler.
- R10: A count write clears the prescaler when the prescaler is assigned to the timer.
- R11: While `halt` is high, neither the count nor the timer-side prescaler advances.
- R12: After reset, the count is 00h, the option field is 3Fh, and the flag, the enable bit and `wdt_tick` are all 0. `cfg_we` loads the option field from `wdata[5:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt | input | 1 | Freezes the timer path |
| ext_pin | input | 1 | External count input, asynchronous |
| wdt_base | input | 1 | Watchdog base-tick pulse, one clock wide |
| cnt_we | input | 1 | Count register write strobe |
| cfg_we | input | 1 | Option field write strobe |
| ien_we | input | 1 | Interrupt-enable write strobe |
| flag_clr | input | 1 | Overflow flag clear strobe |
| wdata | input | 8 | Write data |
| cnt_rd | output | 8 | Current count |
| cfg_rd | output | 6 | Option field: [5] source, [4] edge, [3] prescaler owner, [2:0] rate |
| ien_rd | output | 1 | Interrupt-enable bit |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Masked overflow request |
| wdt_tick | output | 1 | Watchdog tick, divided or passed through |

## Verification
The bench targets the write hold-off by loading a value and counting a fixed number of instruction cycles. A design that skipped the hold-off would end two counts high, and one that held off too long would end low. It times the pin synchronizer edge by edge, so a missing or extra stage shows up as the count moving one clock early or late. It also targets the prescaler clear on a count write: it pre-loads 100 of 256 prescaler events before the write, so a design that forgot the clear would produce a stray step. Rate taps in both owner settings are checked, along with the flag's set-over-clear priority and sticky behaviour, and a per-clock reference model catches any cycle where the count, flag or watchdog tick drifts.

// File: rtl/tt8_pkg.sv
package tt8_pkg;

    localparam int RATE_W  = 3;
    localparam int OPT_W   = 6;
    localparam logic [OPT_W-1:0] OPT_RST = 6'h3F;

    typedef struct packed {
        logic              ext_src;   // 1: count pin edges
        logic              fall_sel;  // 1: falling edge
        logic              pre_wdt;   // 1: prescaler on watchdog path
        logic [RATE_W-1:0] rate;      // tap select
    } opt_t;

endpackage

// File: rtl/tt8_insync.sv
module tt8_insync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic edge_ev
);
    typedef struct packed {
        logic [STAGES:0] sh;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[STAGES-1:0], pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (fall_sel) edge_ev = !st_q.sh[STAGES-1] &&  st_q.sh[STAGES];
        else          edge_ev =  st_q.sh[STAGES-1] && !st_q.sh[STAGES];
    end

    AST_SYNC_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_ev && !fall_sel) |-> $past(pin, STAGES)); // R4
    AST_SYNC_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_ev && fall_sel) |-> !$past(pin, STAGES)); // R3

endmodule

// File: rtl/tt8_prescale.sv
module tt8_prescale #(
    parameter int RATE_W = 3,
    localparam int PRE_W = 1 << RATE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    input  logic [RATE_W-1:0] rate,
    output logic              tmr_hit,
    output logic              wdt_hit
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_t;

    pre_t st_d, st_q;
    logic [PRE_W-1:0] tap;

    generate
        for (genvar k = 0; k < PRE_W; k++) begin : g_tap
            assign tap[k] = &st_q.cnt[k:0];
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (clr)      st_d.cnt = '0;
        else if (adv) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tmr_hit = tap[rate];
    assign wdt_hit = (rate == '0) ? 1'b1 : tap[RATE_W'(rate - 1'b1)];

    AST_PRE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.cnt == '0)); // R10
    AST_PRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !adv) |=> $stable(st_q.cnt)); // R11

endmodule

// File: rtl/tt8_count.sv
module tt8_count #(
    parameter int CNT_W = 8,
    parameter int INH_N = 2,
    localparam int INH_W = $clog2(INH_N + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             step,
    input  logic             inst_tick,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             flag
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [INH_W-1:0] inh;
        logic             flag;
    } cnt_t;

    cnt_t st_d, st_q;
    logic step_ok;
    logic wrap;

    assign step_ok = step && (st_q.inh == '0);
    assign wrap    = step_ok && (st_q.cnt == CNT_MAX);

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.cnt = wdata;
            st_d.inh = INH_W'(INH_N);
        end else begin
            if (step_ok)
                st_d.cnt = st_q.cnt + 1'b1;
            if (inst_tick && st_q.inh != '0)
                st_d.inh = st_q.inh - 1'b1;
        end
        if (wrap && !wr)   st_d.flag = 1'b1;
        else if (flag_clr) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt  = st_q.cnt;
    assign flag = st_q.flag;

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.inh != '0 && !wr) |=> (st_q.cnt == $past(st_q.cnt))); // R5
    AST_WRAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q.cnt) == CNT_MAX && st_q.cnt == '0 && !$past(wr)) |-> st_q.flag); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !flag_clr) |=> st_q.flag); // R6

endmodule

// File: rtl/tt8_timer.sv
module tt8_timer #(
    parameter int CNT_W   = 8,
    parameter int INH_N   = 2,
    parameter int CLK_DIV = 4,
    parameter int SYNC_N  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      halt,
    input  logic                      ext_pin,
    input  logic                      wdt_base,
    input  logic                      cnt_we,
    input  logic                      cfg_we,
    input  logic                      ien_we,
    input  logic                      flag_clr,
    input  logic [CNT_W-1:0]          wdata,
    output logic [CNT_W-1:0]          cnt_rd,
    output logic [tt8_pkg::OPT_W-1:0] cfg_rd,
    output logic                      ien_rd,
    output logic                      ovf_flag,
    output logic                      irq,
    output logic                      wdt_tick
);
    import tt8_pkg::*;

    localparam int PH_W = $clog2(CLK_DIV);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLK_DIV - 1);

    typedef struct packed {
        logic [PH_W-1:0] ph;
        opt_t            opt;
        logic            ien;
        logic            wtick;
    } top_t;

    top_t st_d, st_q;

    logic inst_tick, pin_ev, src_ev, tmr_hit, wdt_hit;
    logic pre_clr, pre_adv, step;
    opt_t opt_new;

    assign opt_new   = opt_t'(wdata[OPT_W-1:0]);
    assign inst_tick = (st_q.ph == PH_LAST);
    assign src_ev    = (st_q.opt.ext_src ? pin_ev : inst_tick) && !halt;
    assign pre_adv   = st_q.opt.pre_wdt ? wdt_base : src_ev;
    assign pre_clr   = (cnt_we && !st_q.opt.pre_wdt) ||
                       (cfg_we && (opt_new.pre_wdt != st_q.opt.pre_wdt));
    assign step      = st_q.opt.pre_wdt ? src_ev : (src_ev && tmr_hit);

    always_comb begin
        st_d    = st_q;
        st_d.ph = (st_q.ph == PH_LAST) ? '0 : st_q.ph + 1'b1;
        if (cfg_we) st_d.opt = opt_new;
        if (ien_we) st_d.ien = wdata[0];
        st_d.wtick = st_q.opt.pre_wdt ? (wdt_base && wdt_hit) : wdt_base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.opt <= opt_t'(OPT_RST);
        end else begin
            st_q     <= st_d;
        end
    end

    tt8_insync #(.STAGES(SYNC_N)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (ext_pin),
        .fall_sel (st_q.opt.fall_sel),
        .edge_ev  (pin_ev)
    );

    tt8_prescale #(.RATE_W(RATE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (pre_clr),
        .adv     (pre_adv),
        .rate    (st_q.opt.rate),
        .tmr_hit (tmr_hit),
        .wdt_hit (wdt_hit)
    );

    tt8_count #(.CNT_W(CNT_W), .INH_N(INH_N)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (cnt_we),
        .wdata     (wdata),
        .step      (step),
        .inst_tick (inst_tick),
        .flag_clr  (flag_clr),
        .cnt       (cnt_rd),
        .flag      (ovf_flag)
    );

    assign cfg_rd   = st_q.opt;
    assign ien_rd   = st_q.ien;
    assign irq      = ovf_flag && st_q.ien;
    assign wdt_tick = st_q.wtick;

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cnt_we) |-> (cnt_rd == $past(cnt_rd) ||
                            cnt_rd == CNT_W'($past(cnt_rd) + 1'b1))); // R2
    AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> (cnt_rd == $past(wdata))); // R1
    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !cnt_we) |=> (cnt_rd == $past(cnt_rd))); // R11
    AST_WDT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.opt.pre_wdt |=> (wdt_tick == $past(wdt_base))); // R8
    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_rd |-> !irq); // R7

endmodule

// File: tb/sim_tt8_timer.sv
`timescale 1ns/1ps
module sim_tt8_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       halt = 1'b0, ext_pin = 1'b0, wdt_base = 1'b0;
    logic       cnt_we = 1'b0, cfg_we = 1'b0, ien_we = 1'b0, flag_clr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] cnt_rd;
    logic [5:0] cfg_rd;
    logic       ien_rd, ovf_flag, irq, wdt_tick;

    int checks = 0;
    int failures = 0;

    // behavioural reference state
    int m_ph, m_cnt, m_inh, m_flag, m_cfg, m_ien, m_pre, m_wt;
    int ps1, ps2, ps3;

    always #2.5 clk = ~clk;

    tt8_timer u0 (
        .clk(clk), .rst_n(rst_n), .halt(halt), .ext_pin(ext_pin),
        .wdt_base(wdt_base), .cnt_we(cnt_we), .cfg_we(cfg_we),
        .ien_we(ien_we), .flag_clr(flag_clr), .wdata(wdata),
        .cnt_rd(cnt_rd), .cfg_rd(cfg_rd), .ien_rd(ien_rd),
        .ovf_flag(ovf_flag), .irq(irq), .wdt_tick(wdt_tick)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int  inst, ev, srcg, wd, r, dv, step, wt, adv, ovf;
        inst = (m_ph == 3) ? 1 : 0;
        m_ph = (m_ph + 1) % 4;
        if (m_cfg[4]) ev = (ps2 == 0 && ps3 == 1) ? 1 : 0;
        else          ev = (ps2 == 1 && ps3 == 0) ? 1 : 0;
        ps3 = ps2; ps2 = ps1; ps1 = int'(ext_pin);
        srcg = ((m_cfg[5] ? ev : inst) != 0 && !halt) ? 1 : 0;
        wd = m_cfg[3];
        r  = m_cfg & 7;
        if (wd == 0) begin
            dv   = 2 << r;
            step = (srcg != 0 && (m_pre % dv) == dv - 1) ? 1 : 0;
            wt   = int'(wdt_base);
            adv  = srcg;
        end else begin
            dv   = 1 << r;
            step = srcg;
            wt   = (wdt_base && (m_pre % dv) == dv - 1) ? 1 : 0;
            adv  = int'(wdt_base);
        end
        if ((cnt_we && wd == 0) || (cfg_we && int'(wdata[3]) != wd)) m_pre = 0;
        else if (adv != 0) m_pre = (m_pre + 1) % 256;
        ovf = 0;
        if (cnt_we) begin
            m_cnt = int'(wdata);
            m_inh = 2;
        end else begin
            if (step != 0 && m_inh == 0) begin
                if (m_cnt == 255) ovf = 1;
                m_cnt = (m_cnt + 1) % 256;
            end
            if (inst != 0 && m_inh > 0) m_inh--;
        end
        if (ovf != 0) m_flag = 1;
        else if (flag_clr) m_flag = 0;
        if (cfg_we) m_cfg = int'(wdata[5:0]);
        if (ien_we) m_ien = int'(wdata[0]);
        m_wt = wt;
    endtask

    task automatic compare_all();
        chk("R2 count vs model", int'(cnt_rd), m_cnt);
        chk("R6 flag vs model", int'(ovf_flag), m_flag);
        chk("R7 irq vs model", int'(irq), (m_flag != 0 && m_ien != 0) ? 1 : 0);
        chk("R9 wdt_tick vs model", int'(wdt_tick), m_wt);
        chk("R12 option vs model", int'(cfg_rd), m_cfg);
        chk("R7 enable vs model", int'(ien_rd), m_ien);
    endtask

    task automatic cyc();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr_cnt(input logic [7:0] v);
        cnt_we = 1'b1; wdata = v; cyc(); cnt_we = 1'b0;
    endtask

    task automatic wr_cfg(input logic [7:0] v);
        cfg_we = 1'b1; wdata = v; cyc(); cfg_we = 1'b0;
    endtask

    task automatic wr_ien(input logic [7:0] v);
        ien_we = 1'b1; wdata = v; cyc(); ien_we = 1'b0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ext_pin = 1'b1; run(4);
            ext_pin = 1'b0; run(4);
        end
    endtask

    task automatic wdt_pulses(input int n, output int seen);
        seen = 0;
        for (int i = 0; i < n; i++) begin
            wdt_base = 1'b1; cyc();
            seen += int'(wdt_tick);
            wdt_base = 1'b0; cyc();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int seen;
        m_ph = 0; m_cnt = 0; m_inh = 0; m_flag = 0; m_cfg = 'h3F;
        m_ien = 0; m_pre = 0; m_wt = 0; ps1 = 0; ps2 = 0; ps3 = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        chk("R12 reset count", int'(cnt_rd), 0);
        chk("R12 reset option", int'(cfg_rd), 'h3F);
        chk("R12 reset flag", int'(ovf_flag), 0);
        chk("R12 reset irq", int'(irq), 0);
        chk("R12 reset enable", int'(ien_rd), 0);

        // R1 write and read back, frozen by halt
        halt = 1'b1;
        wr_cnt(8'hA5);
        chk("R1 readback", int'(cnt_rd), 'hA5);
        halt = 1'b0;

        // R2 / R5 internal clock, watchdog owns prescaler
        wr_cfg(8'h08);
        wr_cnt(8'h10);
        run(40);
        chk("R5 hold-off then R2 steps", int'(cnt_rd), 'h18);

        // R11 halt freezes
        halt = 1'b1;
        run(40);
        chk("R11 halted count", int'(cnt_rd), 'h18);
        halt = 1'b0;

        // R6 / R7 overflow
        wr_cnt(8'hFE);
        run(16);
        chk("R6 wrapped count", int'(cnt_rd), 0);
        chk("R6 flag set", int'(ovf_flag), 1);
        chk("R7 masked irq", int'(irq), 0);
        wr_ien(8'h01);
        chk("R7 unmasked irq", int'(irq), 1);
        run(20);
        chk("R6 flag sticky", int'(ovf_flag), 1);
        flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
        chk("R6 flag cleared", int'(ovf_flag), 0);
        chk("R7 irq dropped", int'(irq), 0);

        // R3 pin rising then falling
        wr_cfg(8'h28);
        wr_cnt(8'h00);
        run(8);
        pulses(5);
        run(4);
        chk("R3 rising edges", int'(cnt_rd), 5);
        wr_cfg(8'h38);
        pulses(3);
        run(4);
        chk("R3 falling edges", int'(cnt_rd), 8);

        // R4 synchronizer latency
        wr_cfg(8'h28);
        run(4);
        ext_pin = 1'b1;
        cyc(); chk("R4 edge 1", int'(cnt_rd), 8);
        cyc(); chk("R4 edge 2", int'(cnt_rd), 8);
        cyc(); chk("R4 edge 3", int'(cnt_rd), 9);
        ext_pin = 1'b0;
        run(4);

        // R8 prescaler on timer, 1:4
        wr_cfg(8'h01);
        wr_cnt(8'h00);
        run(80);
        chk("R8 divided count", int'(cnt_rd), 5);
        wdt_base = 1'b1; cyc(); wdt_base = 1'b0;
        chk("R8 wdt pass", int'(wdt_tick), 1);
        cyc();
        chk("R8 wdt pass low", int'(wdt_tick), 0);

        // R10 count write clears prescaler, 1:256
        wr_cfg(8'h07);
        wr_cnt(8'h00);
        run(400);
        wr_cnt(8'h00);
        run(800);
        chk("R10 prescaler cleared", int'(cnt_rd), 0);

        // R9 prescaler on watchdog
        wr_cfg(8'h0A);
        wdt_pulses(8, seen);
        chk("R9 wdt 1:4", seen, 2);
        wr_cfg(8'h08);
        wdt_pulses(3, seen);
        chk("R9 wdt 1:1", seen, 3);

        run(10);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule